// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block is the configuration front end of a multi-port serial I/O controller. A host sees it as two adjacent byte addresses. Offset 0 is an index port and offset 1 is a data port. After reset the block is locked. It opens only when a strap-selected key byte is written to the index port twice in a row. While it is open, an index write picks a register, and data-port reads and writes reach that register. Writing the exit byte 0xAA to the index port locks the block again.

The register space has two parts. The first holds fixed identification bytes and a device-select register. The second is one bank of configuration registers per logical device. Each bank holds the device's I/O base address, interrupt mode, RS485 control and FIFO control. These values drive the configuration outputs of the serial ports. Each output carries the raw register byte, and the port it feeds decodes the fields.

Top module: `kcp_cfg_port`

## Requirements
- R1: Reset puts the block in the locked state. All configuration outputs and the device-select register reset to 0. A data-port read in that state returns 0xFF. When busRd is low, busRData is 0x00.
- R2: Two consecutive index-port writes of the key byte open the block. KEY_SEL picks the key: 0 gives 0x77, 1 gives 0xA0, 2 gives 0x87 and 3 gives 0x67.
- R3: While locked, an index-port write that is not the key cancels a partly entered key sequence. So key, other, key leaves the block locked.
- R4: While locked, data-port writes change nothing and data-port reads return 0xFF.
- R5: An index-port write of 0xAA while open locks the block. That write does not change the selected index.
- R6: While open, an index-port write that is not 0xAA selects a register, and an index-port read returns the selected index.
- R7: Index 0x20 reads the chip ID low byte and index 0x21 reads the high byte. Index 0x23 reads 0x19 and index 0x24 reads 0x34. Data writes to these four indexes are ignored.
- R8: Index 0x07 is the device-select register (read/write). It routes accesses at indexes 0x60, 0x61, 0x70, 0xF0 and 0xF6 to the bank of the selected device. For device d, devBase[16d+15:16d] = {reg 0x60, reg 0x61}. The bytes at 0x70, 0xF0 and 0xF6 appear on devIrqMode, devRs485 and devFifoCtl at bits [8d+7:8d].
- R9: If the device select is outside LDN_BASE to LDN_BASE+NUM_DEV-1, the bank indexes read 0x00 and writes to them are ignored.
- R10: A data-port read and write in the same cycle return the value the register held before the write. The written value is visible from the next cycle.
- R11: While open, an index that is not implemented reads 0x00 on the data port, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe, one access per cycle |
| busRd | input | 1 | Read strobe |
| busAddr | input | 1 | 0 = index port, 1 = data port |
| busWData | input | 8 | Write data |
| busRData | output | 8 | Read data, combinational in the strobe cycle |
| devBase | output | 16*NUM_DEV | Per-device I/O base address |
| devIrqMode | output | 8*NUM_DEV | Per-device interrupt mode byte (bit 4 share, bits 6:5 mode: 00 level/low, 01 edge/high) |
| devRs485 | output | 8*NUM_DEV | Per-device RS485 byte (bit 5 RTS invert, bit 4 auto direction, bit 3 receive delay, bit 2 transmit delay) |
| devFifoCtl | output | 8*NUM_DEV | Per-device FIFO byte (bits 1:0 = 11 for 128-byte depth, bits 5:4 = 10 for 4x threshold) |

## Verification
A data-port read and a data-port write can land on the same register in the same cycle. The bench provokes this by raising busRd and busWr together on the RS485 index of a written bank. It samples busRData before the edge and expects the old byte, then reads again and expects the new byte on both busRData and the device output. Lock transitions and data accesses can also meet. The bench therefore checks that a data write issued just after the exit byte is absent once the block is reopened.

// File: rtl/kcp_pkg.sv
package kcp_pkg;
  typedef struct packed {
    logic       open;
    logic       dataWr;
    logic [7:0] index;
  } ctlStb_t;

  localparam logic [7:0] EXIT_BYTE = 8'hAA;
  localparam logic [7:0] IDX_LDN   = 8'h07;
  localparam logic [7:0] IDX_CIDL  = 8'h20;
  localparam logic [7:0] IDX_CIDH  = 8'h21;
  localparam logic [7:0] IDX_VIDA  = 8'h23;
  localparam logic [7:0] IDX_VIDB  = 8'h24;
  localparam logic [7:0] IDX_BASEH = 8'h60;
  localparam logic [7:0] IDX_BASEL = 8'h61;
  localparam logic [7:0] IDX_IRQ   = 8'h70;
  localparam logic [7:0] IDX_R485  = 8'hF0;
  localparam logic [7:0] IDX_FIFO  = 8'hF6;
  localparam logic [7:0] VID_A_VAL = 8'h19;
  localparam logic [7:0] VID_B_VAL = 8'h34;

  function automatic logic [7:0] keyOf(input int sel);
    case (sel)
      0:       keyOf = 8'h77;
      1:       keyOf = 8'hA0;
      2:       keyOf = 8'h87;
      default: keyOf = 8'h67;
    endcase
  endfunction
endpackage

// File: rtl/kcp_ctrl.sv
module kcp_ctrl
  import kcp_pkg::*;
#(
  parameter int KEY_SEL = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic       busAddr,
  input  logic [7:0] busWData,
  output ctlStb_t    stb
);
  localparam logic [7:0] KEY = keyOf(KEY_SEL);

  typedef enum logic [1:0] {ST_LOCKED, ST_HALF, ST_OPEN} lockSt_t;
  lockSt_t    state;
  logic [7:0] indexQ;
  logic       idxWr;

  assign idxWr = busWr && !busAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_LOCKED;
      indexQ <= 8'h00;
    end else if (idxWr) begin
      case (state)
        ST_LOCKED: if (busWData == KEY) state <= ST_HALF;
        ST_HALF:   state <= (busWData == KEY) ? ST_OPEN : ST_LOCKED;
        default: begin
          if (busWData == EXIT_BYTE) state  <= ST_LOCKED;
          else                       indexQ <= busWData;
        end
      endcase
    end
  end

  always_comb begin
    stb.open   = (state == ST_OPEN);
    stb.dataWr = stb.open && busWr && busAddr;
    stb.index  = indexQ;
  end
endmodule

// File: rtl/kcp_regs.sv
module kcp_regs
  import kcp_pkg::*;
#(
  parameter int          NUM_DEV  = 4,
  parameter int          LDN_BASE = 0,
  parameter logic [15:0] CHIP_ID  = 16'h0A5C
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStb_t                stb,
  input  logic                   busAddr,
  input  logic [7:0]             busWData,
  output logic [7:0]             rdMux,
  output logic [16*NUM_DEV-1:0]  devBase,
  output logic [8*NUM_DEV-1:0]   devIrqMode,
  output logic [8*NUM_DEV-1:0]   devRs485,
  output logic [8*NUM_DEV-1:0]   devFifoCtl
);
  localparam int         SEL_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam logic [7:0] BASE_B  = 8'(LDN_BASE);
  localparam logic [8:0] COUNT_B = 9'(NUM_DEV);

  logic [7:0]       ldnQ;
  logic [7:0]       offset;
  logic             hit;
  logic [SEL_W-1:0] sel;
  logic [7:0] baseHiQ [NUM_DEV];
  logic [7:0] baseLoQ [NUM_DEV];
  logic [7:0] irqQ    [NUM_DEV];
  logic [7:0] r485Q   [NUM_DEV];
  logic [7:0] fifoQ   [NUM_DEV];

  assign offset = ldnQ - BASE_B;
  assign hit    = {1'b0, offset} < COUNT_B;
  assign sel    = offset[SEL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldnQ <= 8'h00;
      for (int d = 0; d < NUM_DEV; d++) begin
        baseHiQ[d] <= 8'h00;
        baseLoQ[d] <= 8'h00;
        irqQ[d]    <= 8'h00;
        r485Q[d]   <= 8'h00;
        fifoQ[d]   <= 8'h00;
      end
    end else if (stb.dataWr) begin
      if (stb.index == IDX_LDN) ldnQ <= busWData;
      for (int d = 0; d < NUM_DEV; d++) begin
        if (hit && sel == SEL_W'(d)) begin
          case (stb.index)
            IDX_BASEH: baseHiQ[d] <= busWData;
            IDX_BASEL: baseLoQ[d] <= busWData;
            IDX_IRQ:   irqQ[d]    <= busWData;
            IDX_R485:  r485Q[d]   <= busWData;
            IDX_FIFO:  fifoQ[d]   <= busWData;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdMux = 8'hFF;
    if (stb.open) begin
      if (!busAddr) begin
        rdMux = stb.index;
      end else begin
        case (stb.index)
          IDX_LDN:   rdMux = ldnQ;
          IDX_CIDL:  rdMux = CHIP_ID[7:0];
          IDX_CIDH:  rdMux = CHIP_ID[15:8];
          IDX_VIDA:  rdMux = VID_A_VAL;
          IDX_VIDB:  rdMux = VID_B_VAL;
          IDX_BASEH: rdMux = hit ? baseHiQ[sel] : 8'h00;
          IDX_BASEL: rdMux = hit ? baseLoQ[sel] : 8'h00;
          IDX_IRQ:   rdMux = hit ? irqQ[sel]    : 8'h00;
          IDX_R485:  rdMux = hit ? r485Q[sel]   : 8'h00;
          IDX_FIFO:  rdMux = hit ? fifoQ[sel]   : 8'h00;
          default:   rdMux = 8'h00;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : gOut
    assign devBase[16*g +: 16]  = {baseHiQ[g], baseLoQ[g]};
    assign devIrqMode[8*g +: 8] = irqQ[g];
    assign devRs485[8*g +: 8]   = r485Q[g];
    assign devFifoCtl[8*g +: 8] = fifoQ[g];
  end
endmodule

// File: rtl/kcp_cfg_port.sv
module kcp_cfg_port
  import kcp_pkg::*;
#(
  parameter int          KEY_SEL  = 0,
  parameter int          NUM_DEV  = 4,
  parameter int          LDN_BASE = 0,
  parameter logic [15:0] CHIP_ID  = 16'h0A5C
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWr,
  input  logic                  busRd,
  input  logic                  busAddr,
  input  logic [7:0]            busWData,
  output logic [7:0]            busRData,
  output logic [16*NUM_DEV-1:0] devBase,
  output logic [8*NUM_DEV-1:0]  devIrqMode,
  output logic [8*NUM_DEV-1:0]  devRs485,
  output logic [8*NUM_DEV-1:0]  devFifoCtl
);
  ctlStb_t    ctlStb;
  logic [7:0] rdMux;

  kcp_ctrl #(.KEY_SEL(KEY_SEL)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWData(busWData), .stb(ctlStb)
  );

  kcp_regs #(.NUM_DEV(NUM_DEV), .LDN_BASE(LDN_BASE), .CHIP_ID(CHIP_ID)) u_regs (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .busAddr(busAddr),
    .busWData(busWData), .rdMux(rdMux), .devBase(devBase),
    .devIrqMode(devIrqMode), .devRs485(devRs485), .devFifoCtl(devFifoCtl)
  );

  assign busRData = busRd ? rdMux : 8'h00;
endmodule

// File: rtl/kcp_cfg_port_chk.sv
module kcp_cfg_port_chk
  import kcp_pkg::*;
#(
  parameter int KEY_SEL = 0,
  parameter int NUM_DEV = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busWr,
  input logic                  busRd,
  input logic                  busAddr,
  input logic [7:0]            busWData,
  input logic [7:0]            busRData,
  input logic                  isOpen,
  input logic [7:0]            idx,
  input logic [16*NUM_DEV-1:0] devBase,
  input logic [8*NUM_DEV-1:0]  devIrqMode,
  input logic [8*NUM_DEV-1:0]  devRs485,
  input logic [8*NUM_DEV-1:0]  devFifoCtl
);
  localparam logic [7:0] KEY = keyOf(KEY_SEL);

  // R4
  locked_read_ff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!isOpen && busRd && busAddr) |-> busRData == 8'hFF);

  // R4
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!isOpen && busWr && busAddr) |=> ($stable(devBase) && $stable(devIrqMode)
      && $stable(devRs485) && $stable(devFifoCtl)));

  // R5
  exit_relock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isOpen && busWr && !busAddr && busWData == EXIT_BYTE) |=> !isOpen);

  // R2
  unlock_by_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isOpen) |-> $past(busWr && !busAddr && busWData == KEY));

  // R7
  vendor_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isOpen && busRd && busAddr && idx == IDX_VIDA) |-> busRData == VID_A_VAL);
endmodule

bind kcp_cfg_port kcp_cfg_port_chk #(.KEY_SEL(KEY_SEL), .NUM_DEV(NUM_DEV)) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
  .busWData(busWData), .busRData(busRData), .isOpen(ctlStb.open),
  .idx(ctlStb.index), .devBase(devBase), .devIrqMode(devIrqMode),
  .devRs485(devRs485), .devFifoCtl(devFifoCtl)
);

// File: tb/kcp_cfg_port_bench.sv
module kcp_cfg_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 4;
  localparam int NV = 54;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0, busAddr = 1'b0;
  logic [7:0] busWData = 8'h00;
  logic [7:0] busRData;
  logic [16*NDEV-1:0] devBase;
  logic [8*NDEV-1:0] devIrqMode, devRs485, devFifoCtl;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kcp_cfg_port #(.KEY_SEL(0), .NUM_DEV(NDEV), .LDN_BASE(0), .CHIP_ID(16'h0A5C)) u_kcp_cfg_port (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .devBase(devBase),
    .devIrqMode(devIrqMode), .devRs485(devRs485), .devFifoCtl(devFifoCtl)
  );

  // {isRead, addr, wdata, expected read}
  localparam logic [17:0] VEC [NV] = '{
    {1'b1,1'b1,8'h00,8'hFF}, // 0  R1 R4 locked read
    {1'b0,1'b0,8'h77,8'h00}, // 1  key
    {1'b0,1'b0,8'h12,8'h00}, // 2  R3 breaks sequence
    {1'b0,1'b0,8'h77,8'h00}, // 3  key
    {1'b1,1'b1,8'h00,8'hFF}, // 4  R3 still locked
    {1'b0,1'b0,8'h77,8'h00}, // 5  R2 second key opens
    {1'b1,1'b0,8'h00,8'h00}, // 6  R6 index read
    {1'b0,1'b0,8'h23,8'h00}, // 7
    {1'b1,1'b1,8'h00,8'h19}, // 8  R7
    {1'b0,1'b0,8'h24,8'h00}, // 9
    {1'b1,1'b1,8'h00,8'h34}, // 10 R7
    {1'b0,1'b0,8'h20,8'h00}, // 11
    {1'b1,1'b1,8'h00,8'h5C}, // 12 R7
    {1'b0,1'b0,8'h21,8'h00}, // 13
    {1'b1,1'b1,8'h00,8'h0A}, // 14 R7
    {1'b0,1'b1,8'h55,8'h00}, // 15 R7 write to RO
    {1'b1,1'b1,8'h00,8'h0A}, // 16 R7 unchanged
    {1'b0,1'b0,8'h07,8'h00}, // 17
    {1'b0,1'b1,8'h02,8'h00}, // 18
    {1'b1,1'b1,8'h00,8'h02}, // 19 R8 select readback
    {1'b0,1'b0,8'h60,8'h00}, // 20
    {1'b0,1'b1,8'h12,8'h00}, // 21
    {1'b0,1'b0,8'h61,8'h00}, // 22
    {1'b0,1'b1,8'h34,8'h00}, // 23
    {1'b0,1'b0,8'h70,8'h00}, // 24
    {1'b0,1'b1,8'h30,8'h00}, // 25
    {1'b0,1'b0,8'hF0,8'h00}, // 26
    {1'b0,1'b1,8'h3C,8'h00}, // 27
    {1'b0,1'b0,8'hF6,8'h00}, // 28
    {1'b0,1'b1,8'h23,8'h00}, // 29
    {1'b1,1'b0,8'h00,8'hF6}, // 30 R6
    {1'b0,1'b0,8'h07,8'h00}, // 31
    {1'b0,1'b1,8'h01,8'h00}, // 32
    {1'b0,1'b0,8'h60,8'h00}, // 33
    {1'b1,1'b1,8'h00,8'h00}, // 34 R8 other bank
    {1'b0,1'b0,8'h07,8'h00}, // 35
    {1'b0,1'b1,8'h02,8'h00}, // 36
    {1'b0,1'b0,8'h60,8'h00}, // 37
    {1'b1,1'b1,8'h00,8'h12}, // 38 R8
    {1'b0,1'b0,8'h07,8'h00}, // 39
    {1'b0,1'b1,8'h09,8'h00}, // 40 R9 out of range
    {1'b0,1'b0,8'h60,8'h00}, // 41
    {1'b0,1'b1,8'h77,8'h00}, // 42 R9 ignored write
    {1'b1,1'b1,8'h00,8'h00}, // 43 R9
    {1'b0,1'b0,8'h5A,8'h00}, // 44
    {1'b0,1'b1,8'h44,8'h00}, // 45 R11
    {1'b1,1'b1,8'h00,8'h00}, // 46 R11
    {1'b0,1'b0,8'h07,8'h00}, // 47
    {1'b0,1'b0,8'hAA,8'h00}, // 48 R5 exit
    {1'b1,1'b1,8'h00,8'hFF}, // 49 R5 locked
    {1'b0,1'b1,8'h03,8'h00}, // 50 R4 locked write
    {1'b0,1'b0,8'h77,8'h00}, // 51
    {1'b0,1'b0,8'h77,8'h00}, // 52
    {1'b1,1'b1,8'h00,8'h09}  // 53 R4 select kept, R5 index kept
  };

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic rd, input logic a, input logic [7:0] d,
                        input logic [7:0] exp, input string tag);
    @(negedge clk);
    busWr = !rd; busRd = rd; busAddr = a; busWData = d;
    #1;
    if (rd) check(64'(busRData), 64'(exp), tag);
    @(posedge clk);
    #1;
    busWr = 1'b0; busRd = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state at the outputs
    #1;
    check(64'(busRData), 64'h00, "R1 idle rdata");
    check(64'(devBase), 64'h0, "R1 base after reset");
    check(64'({devIrqMode, devRs485}), 64'h0, "R1 bytes after reset");

    for (int i = 0; i < NV; i++)
      access(VEC[i][17], VEC[i][16], VEC[i][15:8], VEC[i][7:0], $sformatf("vector %0d", i));

    // R8 bank contents at outputs, R9 no stray write to device 1
    check(64'(devBase[47:32]), 64'h1234, "R8 dev2 base");
    check(64'(devIrqMode[23:16]), 64'h30, "R8 dev2 irq");
    check(64'(devRs485[23:16]), 64'h3C, "R8 dev2 rs485");
    check(64'(devFifoCtl[23:16]), 64'h23, "R8 dev2 fifo");
    check(64'(devBase[31:0]), 64'h0, "R9 dev0/dev1 base untouched");

    // R10 simultaneous read and write
    access(1'b0, 1'b1, 8'h02, 8'h00, "R10 select");
    access(1'b0, 1'b0, 8'hF0, 8'h00, "R10 index");
    @(negedge clk);
    busWr = 1'b1; busRd = 1'b1; busAddr = 1'b1; busWData = 8'h11;
    #1;
    check(64'(busRData), 64'h3C, "R10 old value");
    @(posedge clk);
    #1;
    busWr = 1'b0; busRd = 1'b0;
    access(1'b1, 1'b1, 8'h00, 8'h11, "R10 new value");
    check(64'(devRs485[23:16]), 64'h11, "R10 output");

    // R1 mid-run reset
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(64'(devBase), 64'h0, "R1 base cleared");
    check(64'({devIrqMode, devRs485, devFifoCtl}), 64'h0, "R1 bytes cleared");
    access(1'b1, 1'b1, 8'h00, 8'hFF, "R1 relocked read");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule